// File: doc/BRIEF.md
# Internal Control Register Bank

This block holds the 64-bit internal control registers of a processor core behind a single indexed read/write port. A six-bit index selects one register. Every index carries its own write rule: a plain full write, a write filtered through a fixed bit mask, a write that only clears, a write that can only set a one-shot flag, or no write at all. Some indices can be written but not read. Reset loads a defined value into every register.

One index is a hybrid cycle register. Its upper half is stored like any other register. Its lower half is the live value of a counter that runs freely from reset. The pipeline can mark an access as speculative through a qualifier input. A write marked this way changes nothing. Read data comes back one cycle after the read request. Any access that the index does not allow gives a one-cycle error pulse in that same cycle.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset every register reads zero, with three exceptions: memory control (index 9) reads 0x6, scratch slot 7 (index 7) reads the CPU_ID parameter, and trap base (index 8) reads the TRAP_BASE parameter.
- R2: A legal read presents its data on rdData in the cycle after rdEn. rdData is zero in every other cycle.
- R3: Scratch slots (indices 0 to 7), trap base (8) and memory control (9) store all 64 written bits.
- R4: Write masks: the level register (11) keeps 0x1F. The trap request (12) and trap enable (13) registers keep 0xF. The software request register (14) keeps 0x7FFF0. The instruction-side mode register (15) and the data-side mode register (16) keep 0x18.
- R5: Further write masks: control/status (17) keeps 0xFF_FFFF_0300, page base (18) keeps bits 63 to 30, cache test (19) keeps 0x1FFB and cache mode (20) keeps 0x3F.
- R6: A write to the exception address register (10) stores the data with bit 1 forced to zero.
- R7: A write to exception summary (21) or exception mask (22) leaves that register at zero, whatever the write data.
- R8: A read of the cycle register (23) returns the stored bits 63 to 32 above the low 32 bits of a counter that advances by one every clock from reset. A write to index 23 stores all bits.
- R9: The first write to the cycle control register (24) sets it to 1 with no error. A later write, while it is nonzero, raises the error flag and changes nothing. A read of index 24 is an error.
- R10: The error flag pulses for one cycle, in the cycle after the access, on any of these: a read of the flush register (26), which is write-only; a write to the interrupt ID register (25), which is read-only and always reads zero; any access to an index from 27 to 63. An erroneous read returns zero data.
- R11: A write with misspec high changes no register and raises no error.
- R12: A read and a write to the same index in the same cycle return the value held before the write. The new value is visible from the next read onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regIdx | input | 6 | Register index |
| wrData | input | 64 | Write data |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| misspec | input | 1 | Marks the access as speculative; a write marked this way is dropped |
| rdData | output | 64 | Registered read data |
| accErr | output | 1 | One-cycle illegal access pulse |

## Verification
The bench sets CPU_ID to 3 and TRAP_BASE to 0x10000. Both reset values then differ from zero and from each other, so a swapped or missing reset load shows up at the ports. CYC_LO_W keeps its default of 32. The counter cannot wrap within the run, so the difference between two cycle-register reads taken a known number of clocks apart has exactly one expected value. The stored upper half stays separate from the live lower half.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int IDX_W    = 6;
  localparam int NUM_REGS = 27;
  localparam int NUM_SCR  = 8;

  localparam logic [IDX_W-1:0] IX_CPU_SCR    = 6'd7;
  localparam logic [IDX_W-1:0] IX_TRAP_BASE  = 6'd8;
  localparam logic [IDX_W-1:0] IX_MEM_CTL    = 6'd9;
  localparam logic [IDX_W-1:0] IX_EXC_ADDR   = 6'd10;
  localparam logic [IDX_W-1:0] IX_LEVEL      = 6'd11;
  localparam logic [IDX_W-1:0] IX_TRAP_REQ   = 6'd12;
  localparam logic [IDX_W-1:0] IX_TRAP_EN    = 6'd13;
  localparam logic [IDX_W-1:0] IX_SOFT_REQ   = 6'd14;
  localparam logic [IDX_W-1:0] IX_IMODE      = 6'd15;
  localparam logic [IDX_W-1:0] IX_DMODE      = 6'd16;
  localparam logic [IDX_W-1:0] IX_CTL_STAT   = 6'd17;
  localparam logic [IDX_W-1:0] IX_PAGE_BASE  = 6'd18;
  localparam logic [IDX_W-1:0] IX_CACHE_TEST = 6'd19;
  localparam logic [IDX_W-1:0] IX_CACHE_MODE = 6'd20;
  localparam logic [IDX_W-1:0] IX_EXC_SUM    = 6'd21;
  localparam logic [IDX_W-1:0] IX_EXC_MASK   = 6'd22;
  localparam logic [IDX_W-1:0] IX_CYC        = 6'd23;
  localparam logic [IDX_W-1:0] IX_CYC_CTL    = 6'd24;
  localparam logic [IDX_W-1:0] IX_INT_ID     = 6'd25;
  localparam logic [IDX_W-1:0] IX_FLUSH      = 6'd26;

  typedef enum logic [2:0] {
    ACC_PLAIN, ACC_CLEAR, ACC_RDONLY, ACC_WRONLY, ACC_ONESHOT, ACC_NONE
  } accKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             doWrite;
    logic             doClear;
    logic             doSet;
    logic             doRead;
    logic [IDX_W-1:0] sel;
  } regStb_t;

  function automatic accKind_t kindOf(input logic [IDX_W-1:0] ix);
    accKind_t k;
    if (ix < IDX_W'(NUM_SCR)) k = ACC_PLAIN;
    else begin
      case (ix)
        IX_EXC_SUM, IX_EXC_MASK: k = ACC_CLEAR;
        IX_INT_ID:               k = ACC_RDONLY;
        IX_FLUSH:                k = ACC_WRONLY;
        IX_CYC_CTL:              k = ACC_ONESHOT;
        default:                 k = (ix < IDX_W'(NUM_REGS)) ? ACC_PLAIN : ACC_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic [63:0] maskOf(input logic [IDX_W-1:0] ix);
    logic [63:0] m;
    case (ix)
      IX_EXC_ADDR:           m = ~64'h2;
      IX_LEVEL:              m = 64'h1F;
      IX_TRAP_REQ,
      IX_TRAP_EN:            m = 64'hF;
      IX_SOFT_REQ:           m = 64'h7_FFF0;
      IX_IMODE, IX_DMODE:    m = 64'h18;
      IX_CTL_STAT:           m = 64'hFF_FFFF_0300;
      IX_PAGE_BASE:          m = 64'hFFFF_FFFF_C000_0000;
      IX_CACHE_TEST:         m = 64'h1FFB;
      IX_CACHE_MODE:         m = 64'h3F;
      default:               m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ctlreg_ctrl.sv
module ctlreg_ctrl
  import ctlreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             misspec,
  input  logic             oneShotSet,
  output regStb_t          stb,
  output logic             accErr
);
  accKind_t kind;
  logic wrLive, rdBad, wrBad;

  always_comb begin
    kind   = kindOf(regIdx);
    wrLive = wrEn && !misspec;
    rdBad  = rdEn && (kind == ACC_WRONLY || kind == ACC_ONESHOT || kind == ACC_NONE);
    wrBad  = wrLive && (kind == ACC_RDONLY || kind == ACC_NONE ||
                        (kind == ACC_ONESHOT && oneShotSet));
    stb.doWrite = wrLive && (kind == ACC_PLAIN || kind == ACC_WRONLY);
    stb.doClear = wrLive && (kind == ACC_CLEAR);
    stb.doSet   = wrLive && (kind == ACC_ONESHOT) && !oneShotSet;
    stb.doRead  = rdEn && !rdBad;
    stb.sel     = regIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) accErr <= 1'b0;
    else     accErr <= rdBad || wrBad;
  end

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    accErr |-> $past(rdEn || wrEn));

  // R11
  spec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && misspec && !rdEn) |=> !accErr);
endmodule

// File: rtl/ctlreg_dp.sv
module ctlreg_dp
  import ctlreg_pkg::*;
#(
  parameter logic [63:0] CPU_ID    = 64'd0,
  parameter logic [63:0] TRAP_BASE = 64'h0,
  parameter int          CYC_LO_W  = 32
)(
  input  logic        clk,
  input  logic        rst,
  input  regStb_t     stb,
  input  logic [63:0] wrData,
  output logic        oneShotSet,
  output logic [63:0] rdData
);
  logic [63:0]         regFile [NUM_REGS];
  logic [CYC_LO_W-1:0] cycLo;
  logic [63:0]         rdMux;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IX = IDX_W'(i);
    localparam logic [63:0] RST_VAL =
      (MY_IX == IX_CPU_SCR)   ? CPU_ID    :
      (MY_IX == IX_TRAP_BASE) ? TRAP_BASE :
      (MY_IX == IX_MEM_CTL)   ? 64'h6     : 64'h0;
    localparam logic [63:0] WR_MASK = maskOf(MY_IX);
    always_ff @(posedge clk) begin
      if (rst) regFile[i] <= RST_VAL;
      else if (stb.sel == MY_IX) begin
        if (stb.doWrite)      regFile[i] <= wrData & WR_MASK;
        else if (stb.doClear) regFile[i] <= 64'h0;
        else if (stb.doSet)   regFile[i] <= 64'h1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cycLo <= '0;
    else     cycLo <= cycLo + 1'b1;
  end

  assign oneShotSet = (regFile[IX_CYC_CTL] != 64'h0);

  always_comb begin
    rdMux = 64'h0;
    for (int k = 0; k < NUM_REGS; k++)
      if (stb.sel == IDX_W'(k)) rdMux = regFile[k];
    if (stb.sel == IX_CYC)
      rdMux = {regFile[IX_CYC][63:CYC_LO_W], cycLo};
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= 64'h0;
    else     rdData <= stb.doRead ? rdMux : 64'h0;
  end

  // R4
  lvl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    regFile[IX_LEVEL][63:5] == '0);

  // R6
  exc_bit_chk: assert property (@(posedge clk) disable iff (rst)
    regFile[IX_EXC_ADDR][1] == 1'b0);

  // R8
  cyc_run_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cycLo == CYC_LO_W'($past(cycLo) + 1'b1));

  // R9
  once_chk: assert property (@(posedge clk) disable iff (rst)
    regFile[IX_CYC_CTL] <= 64'h1);

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.doClear && stb.sel == IX_EXC_SUM) |=> regFile[IX_EXC_SUM] == 64'h0);
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctlreg_pkg::*;
#(
  parameter logic [63:0] CPU_ID    = 64'd0,
  parameter logic [63:0] TRAP_BASE = 64'h0,
  parameter int          CYC_LO_W  = 32
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  regIdx,
  input  logic [63:0] wrData,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        misspec,
  output logic [63:0] rdData,
  output logic        accErr
);
  regStb_t stb;
  logic    oneShotSet;

  ctlreg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .regIdx(regIdx), .wrEn(wrEn), .rdEn(rdEn),
    .misspec(misspec), .oneShotSet(oneShotSet), .stb(stb), .accErr(accErr)
  );

  ctlreg_dp #(.CPU_ID(CPU_ID), .TRAP_BASE(TRAP_BASE), .CYC_LO_W(CYC_LO_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData),
    .oneShotSet(oneShotSet), .rdData(rdData)
  );

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rdEn) |-> rdData == 64'h0);
endmodule

// File: tb/ctl_reg_bank_tb_top.sv
module ctl_reg_bank_tb_top;
  localparam logic [63:0] CPU_ID    = 64'd3;
  localparam logic [63:0] TRAP_BASE = 64'h1_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  regIdx = '0;
  logic [63:0] wrData = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0, misspec = 1'b0;
  logic [63:0] rdData;
  logic        accErr;
  int nChk = 0, nFail = 0;

  always #2 clk = ~clk;

  ctl_reg_bank #(.CPU_ID(CPU_ID), .TRAP_BASE(TRAP_BASE)) dut_i (
    .clk(clk), .rst(rst), .regIdx(regIdx), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .misspec(misspec), .rdData(rdData), .accErr(accErr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  task automatic doAcc(input logic [5:0] ix, input bit wr, input bit rd, input logic [63:0] wd,
                       input bit ms, output logic [63:0] rdv, output logic errv);
    @(negedge clk);
    regIdx = ix; wrEn = wr; rdEn = rd; wrData = wd; misspec = ms;
    @(negedge clk);
    rdv = rdData; errv = accErr;
    wrEn = 1'b0; rdEn = 1'b0; misspec = 1'b0; wrData = '0;
  endtask

  task automatic rdChk(input logic [5:0] ix, input logic [63:0] exp, input string req);
    logic [63:0] v; logic e;
    doAcc(ix, 1'b0, 1'b1, '0, 1'b0, v, e);
    chk(v == exp && !e, req, v, exp);
  endtask

  task automatic wrOnly(input logic [5:0] ix, input logic [63:0] d, output logic e);
    logic [63:0] v;
    doAcc(ix, 1'b1, 1'b0, d, 1'b0, v, e);
  endtask

  task automatic maskChk(input logic [5:0] ix, input logic [63:0] d, input logic [63:0] exp, input string req);
    logic e;
    wrOnly(ix, d, e);
    chk(!e, req, {63'd0, e}, 64'd0);
    rdChk(ix, exp, req);
  endtask

  task automatic tReset();
    rdChk(6'd7, CPU_ID, "R1 cpu scratch");
    rdChk(6'd8, TRAP_BASE, "R1 trap base");
    rdChk(6'd9, 64'h6, "R1 mem ctl");
    rdChk(6'd11, 64'h0, "R1 level");
    rdChk(6'd0, 64'h0, "R1 scratch0");
  endtask

  task automatic tPlain();
    maskChk(6'd3, 64'hA5A5_5A5A_DEAD_0001, 64'hA5A5_5A5A_DEAD_0001, "R3 scratch3");
    maskChk(6'd9, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R3 mem ctl");
    maskChk(6'd8, 64'hFFFF_0000_0000_8000, 64'hFFFF_0000_0000_8000, "R3 trap base");
  endtask

  task automatic tMasks();
    maskChk(6'd11, '1, 64'h1F, "R4 level");
    maskChk(6'd12, '1, 64'hF, "R4 trap req");
    maskChk(6'd13, '1, 64'hF, "R4 trap en");
    maskChk(6'd14, '1, 64'h7_FFF0, "R4 soft req");
    maskChk(6'd15, '1, 64'h18, "R4 imode");
    maskChk(6'd16, 64'h0F, 64'h08, "R4 dmode");
    maskChk(6'd17, '1, 64'hFF_FFFF_0300, "R5 ctl stat");
    maskChk(6'd18, '1, 64'hFFFF_FFFF_C000_0000, "R5 page base");
    maskChk(6'd19, '1, 64'h1FFB, "R5 cache test");
    maskChk(6'd20, '1, 64'h3F, "R5 cache mode");
  endtask

  task automatic tExcAddr();
    maskChk(6'd10, '1, 64'hFFFF_FFFF_FFFF_FFFD, "R6 exc addr ones");
    maskChk(6'd10, 64'h1234_5677, 64'h1234_5675, "R6 exc addr pattern");
  endtask

  task automatic tClear();
    maskChk(6'd21, '1, 64'h0, "R7 exc sum");
    maskChk(6'd22, 64'h55, 64'h0, "R7 exc mask");
  endtask

  task automatic tCycle();
    logic [63:0] a, b; logic e;
    wrOnly(6'd23, 64'hDEAD_BEEF_0000_1111, e);
    chk(!e, "R8 cyc write", {63'd0, e}, 64'd0);
    doAcc(6'd23, 1'b0, 1'b1, '0, 1'b0, a, e);
    repeat (5) @(negedge clk);
    doAcc(6'd23, 1'b0, 1'b1, '0, 1'b0, b, e);
    chk(a[63:32] == 32'hDEAD_BEEF, "R8 cyc upper", a, 64'hDEAD_BEEF_0000_0000);
    chk(b[31:0] - a[31:0] == 32'd7, "R8 cyc live delta", {32'd0, b[31:0] - a[31:0]}, 64'd7);
  endtask

  task automatic tOneShot();
    logic [63:0] v; logic e;
    wrOnly(6'd24, 64'h0, e);
    chk(!e, "R9 first set", {63'd0, e}, 64'd0);
    wrOnly(6'd24, 64'h0, e);
    chk(e, "R9 second set errs", {63'd0, e}, 64'd1);
    doAcc(6'd24, 1'b0, 1'b1, '0, 1'b0, v, e);
    chk(e && v == 64'h0, "R9 read errs", {63'd0, e}, 64'd1);
  endtask

  task automatic tErrors();
    logic [63:0] v; logic e;
    doAcc(6'd26, 1'b0, 1'b1, '0, 1'b0, v, e);
    chk(e && v == 0, "R10 read write-only", {63'd0, e}, 64'd1);
    @(negedge clk);
    chk(!accErr, "R10 pulse one cycle", {63'd0, accErr}, 64'd0);
    wrOnly(6'd26, 64'h77, e);
    chk(!e, "R10 write write-only ok", {63'd0, e}, 64'd0);
    wrOnly(6'd25, 64'h77, e);
    chk(e, "R10 write read-only", {63'd0, e}, 64'd1);
    rdChk(6'd25, 64'h0, "R10 read-only reads zero");
    doAcc(6'd40, 1'b0, 1'b1, '0, 1'b0, v, e);
    chk(e && v == 0, "R10 read undefined", {63'd0, e}, 64'd1);
    wrOnly(6'd63, 64'h1, e);
    chk(e, "R10 write undefined", {63'd0, e}, 64'd1);
  endtask

  task automatic tMisspec();
    logic [63:0] v; logic e;
    doAcc(6'd2, 1'b1, 1'b0, 64'hCAFE, 1'b1, v, e);
    chk(!e, "R11 no err", {63'd0, e}, 64'd0);
    rdChk(6'd2, 64'h0, "R11 scratch2 unchanged");
    doAcc(6'd25, 1'b1, 1'b0, 64'h1, 1'b1, v, e);
    chk(!e, "R11 read-only write dropped quietly", {63'd0, e}, 64'd0);
  endtask

  task automatic tRdWr();
    logic [63:0] v; logic e;
    wrOnly(6'd1, 64'h1111, e);
    doAcc(6'd1, 1'b1, 1'b1, 64'h2222, 1'b0, v, e);
    chk(v == 64'h1111, "R12 old value", v, 64'h1111);
    rdChk(6'd1, 64'h2222, "R12 new value");
    @(negedge clk);
    chk(rdData == 64'h0, "R2 idle zero", rdData, 64'h0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rdData == 0 && !accErr, "R2 reset outputs", rdData, 64'h0);
    tReset();
    tPlain();
    tMasks();
    tExcAddr();
    tClear();
    tCycle();
    tOneShot();
    tErrors();
    tMisspec();
    tRdWr();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule